// File: doc/BRIEF.md
# Host-side data and status interface for a slave controller

This block sits between an external host bus and the internal controller of a slave peripheral. The host sees an 8-bit data bus with an active-low chip select, active-low read and write strobes and one address line. Host writes land in a dedicated input byte buffer. Host reads come either from a separate output byte buffer or from an 8-bit status register. The status register carries two buffer-full flags, two general flags and a nibble the controller may load freely.

The internal controller issues one-cycle commands on an opcode/data port. These commands read the input buffer, load the output buffer, set or clear either general flag, and load the user status nibble.

Host strobes are synchronized to the system clock. All flag updates caused by the host take effect only after the strobe's trailing (rising) edge has been seen. The chip select, address and write data are captured while the strobe is low. The host keeps them steady until the strobe is released.

Top module: `hostBusIface`

## Requirements
- R1: After reset, both buffers, all four flags and the user status nibble read as zero.
- R2: A host write with csN low and a0 low loads hostDin into the input buffer, sets the input-full flag and clears flag F1.
- R3: A host write with csN low and a0 high loads the input buffer, sets the input-full flag and sets flag F1.
- R4: While a host strobe is held low, no flag changes; the flag update happens only after the strobe returns high.
- R5: With a0 low, hostDout shows the output buffer; a host read with csN low and a0 low clears the output-full flag after its trailing edge.
- R6: With a0 high, hostDout shows the status register; a host read with a0 high changes no flag.
- R7: Internal opcode 0x01 clears the input-full flag; intDout always shows the input buffer.
- R8: Internal opcode 0x02 loads cmdData into the output buffer and sets the output-full flag.
- R9: Internal opcodes 0x11/0x10 set/clear F0, and 0x21/0x20 set/clear F1.
- R10: Internal opcode 0x90 copies cmdData[7:4] into status[7:4] and leaves status[3:0] unchanged.
- R11: Host strobes with csN high change neither buffer nor any flag.
- R12: Status bit layout: bit 0 output-full, bit 1 input-full, bit 2 F0, bit 3 F1, bits 7:4 user nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Host chip select, active low |
| rdN | input | 1 | Host read strobe, active low |
| wrN | input | 1 | Host write strobe, active low |
| a0 | input | 1 | Host address: 0 data, 1 status/command |
| hostDin | input | 8 | Host write data |
| hostDout | output | 8 | Host read data (output buffer or status) |
| cmdValid | input | 1 | Internal command valid for one cycle |
| cmdOp | input | 8 | Internal command opcode |
| cmdData | input | 8 | Internal command operand |
| intDout | output | 8 | Input buffer contents for the controller |
| stsOut | output | 8 | Status register for the controller |

## Verification
The bench builds the block with its defaults: an 8-bit data path and a two-stage strobe synchronizer. These values bring the full status byte into view at both the host and the internal port. The bench holds strobes low for several clocks, so the gap between the asserted strobe and the later flag update can be observed. The bench also exercises the two-clock synchronizer latency.

// File: rtl/hostBusPkg.sv
package hostBusPkg;
  localparam int DATA_W = 8;
  localparam int FLAG_W = 4;
  localparam int USER_W = DATA_W - FLAG_W;

  localparam logic [7:0] OP_RD_IN   = 8'h01;
  localparam logic [7:0] OP_LD_OUT  = 8'h02;
  localparam logic [7:0] OP_F0_CLR  = 8'h10;
  localparam logic [7:0] OP_F0_SET  = 8'h11;
  localparam logic [7:0] OP_F1_CLR  = 8'h20;
  localparam logic [7:0] OP_F1_SET  = 8'h21;
  localparam logic [7:0] OP_STS_LD  = 8'h90;

  typedef struct packed {
    logic hostWr;
    logic hostWrCmd;
    logic hostRdData;
    logic intRdIn;
    logic intLdOut;
    logic f0Set;
    logic f0Clr;
    logic f1Set;
    logic f1Clr;
    logic stsLd;
  } hostStrobe_t;
endpackage

// File: rtl/hostIfCtrl.sv
module hostIfCtrl
  import hostBusPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              a0,
  input  logic [DATA_W-1:0] hostDin,
  input  logic              cmdValid,
  input  logic [7:0]        cmdOp,
  output hostStrobe_t       stb,
  output logic [DATA_W-1:0] capData
);
  logic [SYNC_STAGES-1:0] rdPipe, wrPipe;
  logic rdPrev, wrPrev, capCsN, capA0;
  logic rdS, wrS, rdRise, wrRise;

  assign rdS = rdPipe[SYNC_STAGES-1];
  assign wrS = wrPipe[SYNC_STAGES-1];
  assign rdRise = rdS & ~rdPrev;
  assign wrRise = wrS & ~wrPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPipe  <= '1;
      wrPipe  <= '1;
      rdPrev  <= 1'b1;
      wrPrev  <= 1'b1;
      capCsN  <= 1'b1;
      capA0   <= 1'b0;
      capData <= '0;
    end else begin
      rdPipe <= {rdPipe[SYNC_STAGES-2:0], rdN};
      wrPipe <= {wrPipe[SYNC_STAGES-2:0], wrN};
      rdPrev <= rdS;
      wrPrev <= wrS;
      if (!rdN || !wrN) begin
        capCsN <= csN;
        capA0  <= a0;
        if (!wrN) capData <= hostDin;
      end
    end
  end

  always_comb begin
    stb = '0;
    stb.hostWr     = wrRise & ~capCsN;
    stb.hostWrCmd  = capA0;
    stb.hostRdData = rdRise & ~capCsN & ~capA0;
    if (cmdValid) begin
      unique case (cmdOp)
        OP_RD_IN:  stb.intRdIn  = 1'b1;
        OP_LD_OUT: stb.intLdOut = 1'b1;
        OP_F0_CLR: stb.f0Clr    = 1'b1;
        OP_F0_SET: stb.f0Set    = 1'b1;
        OP_F1_CLR: stb.f1Clr    = 1'b1;
        OP_F1_SET: stb.f1Set    = 1'b1;
        OP_STS_LD: stb.stsLd    = 1'b1;
        default: ;
      endcase
    end
  end

  // R4: a host event is only raised once the raw strobe has gone back high
  a_r4_wr_after_release: assert property (@(posedge clk) disable iff (!rstN)
    stb.hostWr |-> wrN);
  a_r4_rd_after_release: assert property (@(posedge clk) disable iff (!rstN)
    stb.hostRdData |-> rdN);
endmodule

// File: rtl/hostIfData.sv
module hostIfData
  import hostBusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       stb,
  input  logic [DATA_W-1:0] capData,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              a0,
  output logic [DATA_W-1:0] hostDout,
  output logic [DATA_W-1:0] intDout,
  output logic [DATA_W-1:0] stsOut
);
  logic [DATA_W-1:0] inBuf, outBuf;
  logic [USER_W-1:0] userNib;
  logic outFull, inFull, f0, f1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBuf   <= '0;
      outBuf  <= '0;
      userNib <= '0;
      outFull <= 1'b0;
      inFull  <= 1'b0;
      f0      <= 1'b0;
      f1      <= 1'b0;
    end else begin
      if (stb.hostWr) inBuf <= capData;
      if (stb.intLdOut) outBuf <= cmdData;
      if (stb.stsLd) userNib <= cmdData[DATA_W-1:FLAG_W];
      // host write wins over an internal read in the same cycle
      if (stb.hostWr) inFull <= 1'b1;
      else if (stb.intRdIn) inFull <= 1'b0;
      // a fresh internal load wins over a host read in the same cycle
      if (stb.intLdOut) outFull <= 1'b1;
      else if (stb.hostRdData) outFull <= 1'b0;
      if (stb.f0Set) f0 <= 1'b1;
      else if (stb.f0Clr) f0 <= 1'b0;
      if (stb.hostWr) f1 <= stb.hostWrCmd;
      else if (stb.f1Set) f1 <= 1'b1;
      else if (stb.f1Clr) f1 <= 1'b0;
    end
  end

  assign stsOut   = {userNib, f1, f0, inFull, outFull};
  assign intDout  = inBuf;
  assign hostDout = a0 ? stsOut : outBuf;

  a_r2_in_full_set: assert property (@(posedge clk) disable iff (!rstN)
    stb.hostWr |=> inFull);
  a_r5_out_full_clr: assert property (@(posedge clk) disable iff (!rstN)
    (stb.hostRdData && !stb.intLdOut) |=> !outFull);
  a_r8_out_full_set: assert property (@(posedge clk) disable iff (!rstN)
    stb.intLdOut |=> outFull);
  a_r10_low_kept: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stsLd && !stb.hostWr && !stb.hostRdData)
      |=> stsOut[FLAG_W-1:0] == $past(stsOut[FLAG_W-1:0]));
endmodule

// File: rtl/hostBusIface.sv
module hostBusIface
  import hostBusPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              a0,
  input  logic [DATA_W-1:0] hostDin,
  output logic [DATA_W-1:0] hostDout,
  input  logic              cmdValid,
  input  logic [7:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  output logic [DATA_W-1:0] intDout,
  output logic [DATA_W-1:0] stsOut
);
  hostStrobe_t       stb;
  logic [DATA_W-1:0] capData;

  hostIfCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .a0(a0),
    .hostDin(hostDin), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .stb(stb), .capData(capData)
  );

  hostIfData uData (
    .clk(clk), .rstN(rstN), .stb(stb), .capData(capData), .cmdData(cmdData),
    .a0(a0), .hostDout(hostDout), .intDout(intDout), .stsOut(stsOut)
  );
endmodule

// File: tb/sim_hostBusIface.sv
`timescale 1ns/1ps
module sim_hostBusIface;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1, a0 = 1'b0;
  logic [7:0] hostDin = '0, cmdOp = '0, cmdData = '0;
  logic cmdValid = 1'b0;
  logic [7:0] hostDout, intDout, stsOut;
  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hostBusIface u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .a0(a0),
    .hostDin(hostDin), .hostDout(hostDout), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdData(cmdData), .intDout(intDout), .stsOut(stsOut)
  );

  // {req[3:0], kind[1:0], op[7:0], data[7:0], expSts[7:0], expD[7:0]}
  // kind 0: internal command, 1: host write (a0 = op[0]), 2: host read (a0 = op[0])
  localparam int NV = 15;
  localparam logic [37:0] VEC [NV] = '{
    {4'd2,  2'd1, 8'h00, 8'hA5, 8'h02, 8'h00},  // R2
    {4'd7,  2'd0, 8'h01, 8'h00, 8'h00, 8'hA5},  // R7
    {4'd3,  2'd1, 8'h01, 8'h3C, 8'h0A, 8'h00},  // R3
    {4'd7,  2'd0, 8'h01, 8'h00, 8'h08, 8'h3C},  // R7
    {4'd8,  2'd0, 8'h02, 8'h5A, 8'h09, 8'h00},  // R8
    {4'd5,  2'd2, 8'h00, 8'h00, 8'h08, 8'h5A},  // R5
    {4'd9,  2'd0, 8'h11, 8'h00, 8'h0C, 8'h00},  // R9
    {4'd10, 2'd0, 8'h90, 8'hF7, 8'hFC, 8'h00},  // R10
    {4'd6,  2'd2, 8'h01, 8'h00, 8'hFC, 8'hFC},  // R6
    {4'd9,  2'd0, 8'h10, 8'h00, 8'hF8, 8'h00},  // R9
    {4'd9,  2'd0, 8'h20, 8'h00, 8'hF0, 8'h00},  // R9
    {4'd10, 2'd0, 8'h90, 8'h30, 8'h30, 8'h00},  // R10
    {4'd9,  2'd0, 8'h21, 8'h00, 8'h38, 8'h00},  // R9
    {4'd2,  2'd1, 8'h00, 8'h11, 8'h32, 8'h00},  // R2
    {4'd7,  2'd0, 8'h01, 8'h00, 8'h30, 8'h11}   // R7
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic intCmd(input logic [7:0] op, input logic [7:0] d);
    @(negedge clk); cmdValid = 1'b1; cmdOp = op; cmdData = d;
    @(negedge clk); cmdValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic sel, input logic addr, input logic [7:0] d);
    @(negedge clk); csN = sel; a0 = addr; hostDin = d;
    @(negedge clk); wrN = 1'b0;
    repeat (3) @(negedge clk);
    wrN = 1'b1;
    repeat (2) @(negedge clk);
    csN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // returns the data seen on hostDout while the strobe is low
  task automatic hostRead(input logic addr, output logic [7:0] seen);
    @(negedge clk); csN = 1'b0; a0 = addr;
    @(negedge clk); rdN = 1'b0;
    repeat (2) @(negedge clk);
    seen = hostDout;
    @(negedge clk); rdN = 1'b1;
    repeat (2) @(negedge clk);
    csN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] seen;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: everything cleared
    check("R1 status", stsOut, 8'h00);
    check("R1 input buffer", intDout, 8'h00);
    a0 = 1'b0; #0.1;
    check("R1 output buffer", hostDout, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VEC[i][37:34], i);
      case (VEC[i][33:32])
        2'd0: begin
          intCmd(VEC[i][31:24], VEC[i][23:16]);
          if (VEC[i][31:24] == 8'h01) check(tag, intDout, VEC[i][7:0]);
        end
        2'd1: hostWrite(1'b0, VEC[i][24], VEC[i][23:16]);
        default: begin
          hostRead(VEC[i][24], seen);
          check(tag, seen, VEC[i][7:0]);
        end
      endcase
      check(tag, stsOut, VEC[i][15:8]);
    end

    // R4: flags hold while the write strobe stays low
    intCmd(8'h01, 8'h00);
    intCmd(8'h20, 8'h00);
    @(negedge clk); csN = 1'b0; a0 = 1'b1; hostDin = 8'h77;
    @(negedge clk); wrN = 1'b0;
    repeat (8) @(negedge clk);
    check("R4 held low", stsOut, 8'h30);
    wrN = 1'b1;
    repeat (2) @(negedge clk);
    csN = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 after release", stsOut, 8'h3A);
    check("R3 buffer", intDout, 8'h77);

    // R11: strobes with chip select high are ignored
    hostWrite(1'b1, 1'b0, 8'hEE);
    check("R11 write status", stsOut, 8'h3A);
    check("R11 write buffer", intDout, 8'h77);
    intCmd(8'h02, 8'h44);
    @(negedge clk); csN = 1'b1; a0 = 1'b0;
    @(negedge clk); rdN = 1'b0;
    repeat (3) @(negedge clk); rdN = 1'b1;
    repeat (6) @(negedge clk);
    check("R11 read status", stsOut, 8'h3B);

    // R12: bit layout from a clean reset
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after second reset", stsOut, 8'h00);
    intCmd(8'h02, 8'h99);
    check("R12 bit0 output-full", stsOut, 8'h01);
    hostWrite(1'b0, 1'b0, 8'h12);
    check("R12 bit1 input-full", stsOut, 8'h03);
    intCmd(8'h11, 8'h00);
    check("R12 bit2 F0", stsOut, 8'h07);
    intCmd(8'h21, 8'h00);
    check("R12 bit3 F1", stsOut, 8'h0F);
    intCmd(8'h90, 8'hA0);
    check("R12 user nibble", stsOut, 8'hAF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule